// File: doc/BRIEF.md
# Memory-mapped stream I/O controller

This block sits on the processor's word-addressed memory port and claims four word locations at the very top of the address space. Two of them belong to an input channel fed by a word stream source with an end-of-file marker. The other two belong to an output channel that drives a word stream sink. Each channel has one data word and one status word. Every other access is forwarded to ordinary memory.

Software starts a transfer by storing zero to a status word. The block then reports progress by changing that status. Zero means a transfer is under way. One means the channel is idle and the last transfer finished. Minus one, on the input side only, means the source hit end-of-file. Input words are captured into the input data word. Output words are written into the output data word before the send is started. Both stream edges use valid/ready handshakes.

Top module: `mmio_stream_ctrl`

## Requirements
- R1: After reset both status words read 1 (0x00000001), both data words read 0, `src_ready_o` is low and `snk_valid_o` is low.
- R2: The location map is: 0xFFFFFFFF is the input data word, 0xFFFFFFFE the input status, 0xFFFFFFFD the output data word and 0xFFFFFFFC the output status. A read of one of these locations returns its value on `req_rdata_o` in the same cycle. Status reads are sign-extended to 32 bits: 1 gives 0x00000001, 0 gives 0x00000000 and -1 gives 0xFFFFFFFF.
- R3: A write of 0 to the input status while it reads 1 or -1 makes it read 0 from the next cycle. `src_ready_o` stays high for as long as the status is 0.
- R4: A source handshake (`src_valid_i` and `src_ready_o` both high) with `src_eof_i` low stores `src_data_i` in the input data word and sets the input status to 1. With `src_eof_i` high, the status becomes -1 and the data word is left unchanged.
- R5: A write of 0 to a status word that already reads 0 is ignored. A write of any nonzero value to either status word is ignored.
- R6: A write to the output data word stores the value while the output status is not 0, and is ignored while it is 0. A write of 0 to an output status of 1 raises `snk_valid_o`, with `snk_data_o` equal to the output data word.
- R7: `snk_valid_o` stays high and `snk_data_o` stays stable until `snk_ready_i` is seen. In the cycle after acceptance, `snk_valid_o` is low and the output status reads 1.
- R8: An access to any address other than the four locations raises `mem_req_o` and passes the write enable, address and write data through. Its read data comes from `mem_rdata_i`. Accesses to the four locations never raise `mem_req_o`.
- R9: Reads of either data word have no side effect, and writes to the input data word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Processor access strobe |
| req_we_i | input | 1 | Processor write enable |
| req_addr_i | input | 32 | Processor word address |
| req_wdata_i | input | 32 | Processor write data |
| req_rdata_o | output | 32 | Read data back to the processor |
| mem_req_o | output | 1 | Forwarded memory access strobe |
| mem_we_o | output | 1 | Forwarded memory write enable |
| mem_addr_o | output | 32 | Forwarded memory address |
| mem_wdata_o | output | 32 | Forwarded memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| src_valid_i | input | 1 | Source word valid |
| src_data_i | input | 32 | Source word |
| src_eof_i | input | 1 | Source end-of-file marker, qualified by valid |
| src_ready_o | output | 1 | Input channel ready for one word |
| snk_valid_o | output | 1 | Output word valid |
| snk_data_o | output | 32 | Output word |
| snk_ready_i | input | 1 | Sink accepts the word |

## Verification
The bench repeats a start store while a fetch is still in flight. A design that restarts on it would lose or duplicate a word. It also stores nonzero values to the status words, and a design that decodes any write as a start would begin transfers nobody asked for. An end-of-file word must leave the old input data intact, so a design that captured on every handshake would corrupt it. The bench holds the sink stalled while rewriting the output data word, which exposes a sink word that changes before acceptance. Addresses just below the I/O window, such as 0xFFFFFFFB, must still reach memory, so an over-wide decode would swallow them.

// File: rtl/mmio_stream_pkg.sv
package mmio_stream_pkg;
  // two-bit two's complement status: sign-extends directly to the bus word
  typedef enum logic [1:0] {
    ST_BUSY = 2'b00,
    ST_DONE = 2'b01,
    ST_EOF  = 2'b11
  } io_stat_e;

  localparam int unsigned NUM_IO_LOC = 4;
  localparam int unsigned LOC_IN_DATA  = 0;
  localparam int unsigned LOC_IN_STAT  = 1;
  localparam int unsigned LOC_OUT_DATA = 2;
  localparam int unsigned LOC_OUT_STAT = 3;
endpackage

// File: rtl/mmio_addr_dec.sv
module mmio_addr_dec
  import mmio_stream_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                  valid_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [NUM_IO_LOC-1:0] io_sel_o,
  output logic                  mem_sel_o
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  for (genvar k = 0; k < NUM_IO_LOC; k++) begin : g_loc
    localparam logic [ADDR_W-1:0] LOC_ADDR = TOP_ADDR - ADDR_W'(k);
    assign io_sel_o[k] = valid_i && (addr_i == LOC_ADDR);
  end

  assign mem_sel_o = valid_i && (io_sel_o == '0);

  // R2: at most one target per access
  always_comb begin
    a_r2_single_target: assert ($onehot0({io_sel_o, mem_sel_o}));
  end
endmodule

// File: rtl/mmio_in_chan.sv
module mmio_in_chan
  import mmio_stream_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_eof_i,
  output logic              src_ready_o,
  output logic [DATA_W-1:0] data_o,
  output io_stat_e          stat_o
);
  io_stat_e          stat_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= ST_DONE;
      data_q <= '0;
    end else if (stat_q == ST_BUSY) begin
      if (src_valid_i) begin
        if (src_eof_i) begin
          stat_q <= ST_EOF;
        end else begin
          stat_q <= ST_DONE;
          data_q <= src_data_i;
        end
      end
    end else if (start_i) begin
      stat_q <= ST_BUSY;
    end
  end

  assign src_ready_o = (stat_q == ST_BUSY);
  assign data_o      = data_q;
  assign stat_o      = stat_q;

  a_r3_start_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !src_ready_o) |=> src_ready_o);
  a_r4_capture_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_o && src_valid_i && !src_eof_i) |=>
      (data_o == $past(src_data_i)) && (stat_o == ST_DONE));
  a_r4_eof_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_o && src_valid_i && src_eof_i) |=> (stat_o == ST_EOF) && $stable(data_o));
  a_r5_fetch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_o && !src_valid_i) |=> src_ready_o && $stable(data_o));
endmodule

// File: rtl/mmio_out_chan.sv
module mmio_out_chan
  import mmio_stream_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              start_i,
  output logic              snk_valid_o,
  output logic [DATA_W-1:0] snk_data_o,
  input  logic              snk_ready_i,
  output io_stat_e          stat_o
);
  io_stat_e          stat_q;
  logic [DATA_W-1:0] data_q;
  logic              busy;

  assign busy = (stat_q == ST_BUSY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= ST_DONE;
      data_q <= '0;
    end else if (busy) begin
      if (snk_ready_i) stat_q <= ST_DONE;
    end else begin
      if (data_we_i) data_q <= data_i;
      if (start_i)   stat_q <= ST_BUSY;
    end
  end

  assign snk_valid_o = busy;
  assign snk_data_o  = data_q;
  assign stat_o      = stat_q;

  a_r6_start_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !snk_valid_o) |=> snk_valid_o);
  a_r7_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snk_valid_o && !snk_ready_i) |=> snk_valid_o && $stable(snk_data_o));
  a_r7_done_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snk_valid_o && snk_ready_i) |=> !snk_valid_o && (stat_o == ST_DONE));
endmodule

// File: rtl/mmio_stream_ctrl.sv
module mmio_stream_ctrl
  import mmio_stream_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_eof_i,
  output logic              src_ready_o,
  output logic              snk_valid_o,
  output logic [DATA_W-1:0] snk_data_o,
  input  logic              snk_ready_i
);
  localparam int unsigned STAT_W = $bits(io_stat_e);

  logic [NUM_IO_LOC-1:0] io_sel;
  logic                  mem_sel;
  logic                  wr_zero;
  io_stat_e              in_stat, out_stat;
  logic [DATA_W-1:0]     in_data, out_data;
  logic [DATA_W-1:0]     in_stat_word, out_stat_word;

  mmio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i   (req_valid_i),
    .addr_i    (req_addr_i),
    .io_sel_o  (io_sel),
    .mem_sel_o (mem_sel)
  );

  assign wr_zero = req_we_i && (req_wdata_i == '0);

  mmio_in_chan #(.DATA_W(DATA_W)) u_in (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (io_sel[LOC_IN_STAT] && wr_zero),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .src_eof_i   (src_eof_i),
    .src_ready_o (src_ready_o),
    .data_o      (in_data),
    .stat_o      (in_stat)
  );

  mmio_out_chan #(.DATA_W(DATA_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_we_i   (io_sel[LOC_OUT_DATA] && req_we_i),
    .data_i      (req_wdata_i),
    .start_i     (io_sel[LOC_OUT_STAT] && wr_zero),
    .snk_valid_o (snk_valid_o),
    .snk_data_o  (snk_data_o),
    .snk_ready_i (snk_ready_i),
    .stat_o      (out_stat)
  );

  assign out_data      = snk_data_o;
  assign in_stat_word  = {{(DATA_W-STAT_W){in_stat[STAT_W-1]}}, in_stat};
  assign out_stat_word = {{(DATA_W-STAT_W){out_stat[STAT_W-1]}}, out_stat};

  always_comb begin
    unique case (1'b1)
      io_sel[LOC_IN_DATA]:  req_rdata_o = in_data;
      io_sel[LOC_IN_STAT]:  req_rdata_o = in_stat_word;
      io_sel[LOC_OUT_DATA]: req_rdata_o = out_data;
      io_sel[LOC_OUT_STAT]: req_rdata_o = out_stat_word;
      default:              req_rdata_o = mem_rdata_i;
    endcase
  end

  assign mem_req_o   = mem_sel;
  assign mem_we_o    = mem_sel && req_we_i;
  assign mem_addr_o  = req_addr_i;
  assign mem_wdata_o = req_wdata_i;

  // R8: the top four words never reach memory
  a_r8_io_not_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_addr_i[ADDR_W-1:2] == '1)) |-> !mem_req_o);
  a_r8_others_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_addr_i[ADDR_W-1:2] != '1)) |-> mem_req_o && (mem_we_o == req_we_i));
endmodule

// File: tb/sim_mmio_stream_ctrl.sv
module sim_mmio_stream_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [31:0] req_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        src_valid = 1'b0, src_eof = 1'b0;
  logic [31:0] src_data = '0;
  logic        src_ready;
  logic        snk_valid;
  logic [31:0] snk_data;
  logic        snk_ready = 1'b0;

  localparam logic [31:0] A_IN_D  = 32'hFFFF_FFFF;
  localparam logic [31:0] A_IN_S  = 32'hFFFF_FFFE;
  localparam logic [31:0] A_OUT_D = 32'hFFFF_FFFD;
  localparam logic [31:0] A_OUT_S = 32'hFFFF_FFFC;
  localparam logic [31:0] MEM_KEY = 32'h5A5A_0000;

  always #5 clk = ~clk;

  assign mem_rdata = mem_addr ^ MEM_KEY;

  mmio_stream_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_rdata_o(req_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_eof_i(src_eof),
    .src_ready_o(src_ready),
    .snk_valid_o(snk_valid), .snk_data_o(snk_data), .snk_ready_i(snk_ready)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // behavioural reference: status as integers -1/0/1
  int          m_in_stat, m_out_stat;
  logic [31:0] m_in_data, m_out_data;

  function automatic logic is_io(logic [31:0] a);
    return (a == A_IN_D) || (a == A_IN_S) || (a == A_OUT_D) || (a == A_OUT_S);
  endfunction

  function automatic logic [31:0] m_read(logic [31:0] a);
    if (a == A_IN_D)  return m_in_data;
    if (a == A_IN_S)  return 32'(m_in_stat);
    if (a == A_OUT_D) return m_out_data;
    if (a == A_OUT_S) return 32'(m_out_stat);
    return a ^ MEM_KEY;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_in_stat = 1; m_out_stat = 1; m_in_data = '0; m_out_data = '0;
    end else begin
      int old_in, old_out;
      old_in = m_in_stat;
      old_out = m_out_stat;
      if (old_in == 0 && src_valid) begin
        if (src_eof) m_in_stat = -1;
        else begin m_in_stat = 1; m_in_data = src_data; end
      end
      if (old_out == 0 && snk_ready) m_out_stat = 1;
      if (req_valid && req_we) begin
        if (req_addr == A_IN_S && req_wdata == 0 && old_in != 0) m_in_stat = 0;
        if (req_addr == A_OUT_D && old_out != 0) m_out_data = req_wdata;
        if (req_addr == A_OUT_S && req_wdata == 0 && old_out != 0) m_out_stat = 0;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_ni && !finished) begin
      logic fwd;
      fwd = req_valid && !is_io(req_addr);
      if (req_valid) chk("R2 read data", req_rdata, m_read(req_addr));
      chk("R3 src_ready", {31'd0, src_ready}, {31'd0, m_in_stat == 0});
      chk("R7 snk_valid", {31'd0, snk_valid}, {31'd0, m_out_stat == 0});
      chk("R6 snk_data", snk_data, m_out_data);
      chk("R8 mem_req", {31'd0, mem_req}, {31'd0, fwd});
      chk("R8 mem_we", {31'd0, mem_we}, {31'd0, fwd && req_we});
      if (fwd) begin
        chk("R8 mem_addr", mem_addr, req_addr);
        chk("R8 mem_wdata", mem_wdata, req_wdata);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    tick();
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [31:0] a, logic [31:0] exp);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    #1 chk(tag, req_rdata, exp);
    tick();
    req_valid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 input status", A_IN_S, 32'h1);
    rd("R1 output status", A_OUT_S, 32'h1);
    rd("R1 input data", A_IN_D, 32'h0);
    chk("R1 src_ready", {31'd0, src_ready}, 32'h0);
    chk("R1 snk_valid", {31'd0, snk_valid}, 32'h0);
    // R3 start fetch
    wr(A_IN_S, 32'h0);
    chk("R3 src_ready after start", {31'd0, src_ready}, 32'h1);
    rd("R3 status in progress", A_IN_S, 32'h0);
    // R5 repeat start and nonzero writes ignored
    wr(A_IN_S, 32'h0);
    wr(A_IN_S, 32'h7);
    rd("R5 status still 0", A_IN_S, 32'h0);
    // R4 capture
    src_valid = 1'b1; src_data = 32'hA5A5_1234; src_eof = 1'b0;
    tick();
    src_valid = 1'b0;
    rd("R4 input word", A_IN_D, 32'hA5A5_1234);
    rd("R4 status done", A_IN_S, 32'h1);
    // R9 data reads and input data writes have no effect
    rd("R9 second read", A_IN_D, 32'hA5A5_1234);
    wr(A_IN_D, 32'h0000_1111);
    rd("R9 input data unchanged", A_IN_D, 32'hA5A5_1234);
    wr(A_IN_S, 32'h3);
    rd("R5 nonzero write ignored", A_IN_S, 32'h1);
    // R4 end-of-file
    wr(A_IN_S, 32'h0);
    src_valid = 1'b1; src_data = 32'hDEAD_BEEF; src_eof = 1'b1;
    tick();
    src_valid = 1'b0; src_eof = 1'b0;
    rd("R4 eof status", A_IN_S, 32'hFFFF_FFFF);
    rd("R4 eof keeps data", A_IN_D, 32'hA5A5_1234);
    // R3 restart after end-of-file
    wr(A_IN_S, 32'h0);
    rd("R3 restart from eof", A_IN_S, 32'h0);
    src_valid = 1'b1; src_data = 32'h0000_0077;
    tick();
    src_valid = 1'b0;
    rd("R4 word after restart", A_IN_D, 32'h0000_0077);
    // R6 output send
    wr(A_OUT_D, 32'hCAFE_0001);
    rd("R6 output data stored", A_OUT_D, 32'hCAFE_0001);
    wr(A_OUT_S, 32'h0);
    chk("R6 snk_valid raised", {31'd0, snk_valid}, 32'h1);
    chk("R6 snk_data", snk_data, 32'hCAFE_0001);
    wr(A_OUT_D, 32'hBEEF_0002);
    chk("R6 data write while busy ignored", snk_data, 32'hCAFE_0001);
    rd("R6 status in progress", A_OUT_S, 32'h0);
    tick();
    chk("R7 held while stalled", {31'd0, snk_valid}, 32'h1);
    snk_ready = 1'b1;
    tick();
    snk_ready = 1'b0;
    chk("R7 valid dropped", {31'd0, snk_valid}, 32'h0);
    rd("R7 status done", A_OUT_S, 32'h1);
    // R8 forwarding
    req_valid = 1'b1; req_we = 1'b1; req_addr = 32'd100; req_wdata = 32'h55;
    #1 chk("R8 write forwarded", {31'd0, mem_we}, 32'h1);
    tick();
    req_we = 1'b0;
    rd("R8 read from memory", 32'd100, 32'd100 ^ MEM_KEY);
    rd("R8 boundary below window", 32'hFFFF_FFFB, 32'hFFFF_FFFB ^ MEM_KEY);
    // randomized phase, checked against the reference every clock
    for (int i = 0; i < 6000; i++) begin
      int sel;
      sel = int'($urandom % 6);
      req_valid = ($urandom % 4) != 0;
      req_we = $urandom % 2;
      case (sel)
        0: req_addr = A_IN_D;
        1: req_addr = A_IN_S;
        2: req_addr = A_OUT_D;
        3: req_addr = A_OUT_S;
        4: req_addr = 32'hFFFF_FFFB;
        default: req_addr = $urandom % 1024;
      endcase
      req_wdata = ($urandom % 2) ? 32'h0 : $urandom;
      src_valid = $urandom % 2;
      src_eof = ($urandom % 8) == 0;
      src_data = $urandom;
      snk_ready = $urandom % 2;
      tick();
    end
    req_valid = 1'b0; src_valid = 1'b0; snk_ready = 1'b0;
    tick();
    finish_run();
  end
endmodule